// File: doc/BRIEF.md
# Low-Power Link Turnaround Controller

This block moves transmit ownership of a low-power data lane from one end of the link to the other. While it owns the lane it idles in the stop state (LP-11). When asked to give the lane away, it drives a request pattern and then a long bridge state, and finally stops driving. While it listens, it watches for the far end to begin the same handover. After a bounded settling wait it drives its own bridge state and returns to stop as the new owner.

Every timed interval is a whole number of LPX periods, and `lpxCycles` gives the length of one period in clock cycles. A single period counter counts the periods, so the bridge lengths need no multiplier. A line state that does not fit the handshake, or a far end that never reaches the bridge, drops the block back to listening and raises a sticky error flag.

Line pairs are written {positive wire, negative wire}: `2'b11` is LP-11, `2'b10` is LP-10, `2'b01` is LP-01 and `2'b00` is LP-00.

Top module: `lane_turnaround`

## Requirements
- R1: While reset is held and directly after it, the block owns the lane: isTx=1, driveEn=1, lineOut=2'b11, turnErr=0.
- R2: Let L be the effective LPX length in cycles. A giveReq sampled high while the block idles as owner drives lineOut=2'b10 for the L cycles after that edge, then 2'b00 for the next L cycles.
- R3: The release then keeps driving 2'b00 for 4×L more cycles, so the driven LP-00 run lasts 5×L cycles. After that, driveEn=0 and isTx=0. lineOut reads 2'b00 whenever driveEn is 0.
- R4: giveReq has no effect while a release is in progress or while the block listens.
- R5: A take-over starts only when lineIn goes from 2'b11 to 2'b10 while the block listens. lineIn is ignored while the block idles as owner.
- R6: Count edges from the edge that first sampled lineIn=2'b10 as edge 0. Driving starts (driveEn=1, lineOut=2'b00, isTx=0) right after the first edge n with L+1 ≤ n ≤ 2×L at which lineIn is sampled as 2'b00.
- R7: The take-over bridge drives 2'b00 for 5×L cycles. The block then drives 2'b11 with isTx=1.
- R8: If lineIn is sampled as 2'b11 or 2'b01 during the wait, or edge 2×L passes without a qualifying 2'b00, the block returns to listening with turnErr=1. turnErr stays set until the next handover begins (a release request or a take-over start).
- R9: lpxCycles=0 behaves exactly as lpxCycles=1.
- R10: Every 2'b10 or 2'b00 state the block drives lasts at least L cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| giveReq | input | 1 | Request to hand the lane to the far end |
| lineIn | input | 2 | Sampled lane pair {pos, neg} |
| lpxCycles | input | CW | LPX period length in clock cycles (0 acts as 1) |
| lineOut | output | 2 | Lane pair value to drive {pos, neg} |
| driveEn | output | 1 | Line drivers enabled |
| isTx | output | 1 | 1 when this end owns the lane |
| turnErr | output | 1 | Sticky handshake error flag |

## Verification
The duration checks assume that lpxCycles does not change while a handover is in progress. The stimulus changes it only while the block sits idle, either as owner or as listener. They also assume that lineIn reaches the block already synchronised to clk. The bench therefore drives lineIn only on falling edges, and always returns it to 2'b11 for at least one edge before a new take-over, so the start transition is clean. The sweeps cover LPX lengths 0 to 5. For each length they move the far end's bridge onset across both ends of the settling window and one cycle past it.

// File: rtl/turn_pkg.sv
package turn_pkg;

  localparam logic [1:0] LP11 = 2'b11;
  localparam logic [1:0] LP10 = 2'b10;
  localparam logic [1:0] LP01 = 2'b01;
  localparam logic [1:0] LP00 = 2'b00;

  typedef enum logic [2:0] {
    ST_TXIDLE,
    ST_REQ,
    ST_LOW,
    ST_GO,
    ST_RXIDLE,
    ST_SURE,
    ST_GET
  } turnState_t;

  // Strobes from the control to the timing datapath
  typedef struct packed {
    logic restart;  // zero cycle and period counters
    logic countEn;  // advance the counters this cycle
  } timerCtl_t;

endpackage

// File: rtl/turn_timer.sv
module turn_timer
  import turn_pkg::*;
#(
  parameter int CW = 8,
  parameter int PW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  timerCtl_t     ctl,
  input  logic [CW-1:0] lpxCycles,
  input  logic [1:0]    lineIn,
  output logic          lpxTick,
  output logic [PW-1:0] periodCnt,
  output logic          startSeen
);

  logic [CW-1:0] cycCnt;
  logic [1:0]    prevLine;
  logic          wrap;

  // A length of zero wraps every cycle, the same as a length of one
  assign wrap    = ({1'b0, cycCnt} + 1'b1) >= {1'b0, lpxCycles};
  assign lpxTick = ctl.countEn && wrap;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cycCnt    <= '0;
      periodCnt <= '0;
    end else if (ctl.restart) begin
      cycCnt    <= '0;
      periodCnt <= '0;
    end else if (ctl.countEn) begin
      if (wrap) begin
        cycCnt    <= '0;
        periodCnt <= periodCnt + 1'b1;
      end else begin
        cycCnt <= cycCnt + 1'b1;
      end
    end
  end

  // Stop-to-request transition seen from the far end
  always_ff @(posedge clk) begin
    if (!rst_n) prevLine <= LP00;
    else        prevLine <= lineIn;
  end

  assign startSeen = (prevLine == LP11) && (lineIn == LP10);

endmodule

// File: rtl/turn_fsm.sv
module turn_fsm
  import turn_pkg::*;
#(
  parameter int PW          = 3,
  parameter int GIVE_BRIDGE = 4,
  parameter int TAKE_BRIDGE = 5,
  parameter int SURE_MAX    = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          giveReq,
  input  logic [1:0]    lineIn,
  input  logic          startSeen,
  input  logic          lpxTick,
  input  logic [PW-1:0] periodCnt,
  output timerCtl_t     ctl,
  output logic [1:0]    lineOut,
  output logic          driveEn,
  output logic          isTx,
  output logic          turnErr
);

  localparam logic [PW-1:0] GO_LAST   = PW'(GIVE_BRIDGE - 1);
  localparam logic [PW-1:0] GET_LAST  = PW'(TAKE_BRIDGE - 1);
  localparam logic [PW-1:0] SURE_LAST = PW'(SURE_MAX - 1);

  turnState_t state, nextState;
  logic       errNow;

  always_comb begin
    nextState = state;
    errNow    = 1'b0;
    unique case (state)
      ST_TXIDLE: if (giveReq) nextState = ST_REQ;
      ST_REQ:    if (lpxTick) nextState = ST_LOW;
      ST_LOW:    if (lpxTick) nextState = ST_GO;
      ST_GO:     if (lpxTick && periodCnt == GO_LAST) nextState = ST_RXIDLE;
      ST_RXIDLE: if (startSeen) nextState = ST_SURE;
      ST_SURE: begin
        if (lineIn == LP11 || lineIn == LP01) begin
          nextState = ST_RXIDLE;
          errNow    = 1'b1;
        end else if (lineIn == LP00 && periodCnt != '0) begin
          nextState = ST_GET;
        end else if (lpxTick && periodCnt == SURE_LAST) begin
          nextState = ST_RXIDLE;
          errNow    = 1'b1;
        end
      end
      ST_GET:    if (lpxTick && periodCnt == GET_LAST) nextState = ST_TXIDLE;
      default:   nextState = ST_TXIDLE;
    endcase
  end

  assign ctl.restart = (nextState != state);
  assign ctl.countEn = (state != ST_TXIDLE) && (state != ST_RXIDLE);

  always_ff @(posedge clk) begin
    if (!rst_n) state <= ST_TXIDLE;
    else        state <= nextState;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)
      turnErr <= 1'b0;
    else if (errNow)
      turnErr <= 1'b1;
    else if (ctl.restart && (nextState == ST_REQ || nextState == ST_SURE))
      turnErr <= 1'b0;
  end

  always_comb begin
    lineOut = LP00;
    driveEn = 1'b0;
    isTx    = 1'b0;
    unique case (state)
      ST_TXIDLE: begin lineOut = LP11; driveEn = 1'b1; isTx = 1'b1; end
      ST_REQ:    begin lineOut = LP10; driveEn = 1'b1; isTx = 1'b1; end
      ST_LOW,
      ST_GO:     begin lineOut = LP00; driveEn = 1'b1; isTx = 1'b1; end
      ST_GET:    begin lineOut = LP00; driveEn = 1'b1; end
      default:   ;
    endcase
  end

endmodule

// File: rtl/lane_turnaround.sv
module lane_turnaround
  import turn_pkg::*;
#(
  parameter int CW          = 8,
  parameter int GIVE_BRIDGE = 4,
  parameter int TAKE_BRIDGE = 5,
  parameter int SURE_MAX    = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          giveReq,
  input  logic [1:0]    lineIn,
  input  logic [CW-1:0] lpxCycles,
  output logic [1:0]    lineOut,
  output logic          driveEn,
  output logic          isTx,
  output logic          turnErr
);

  localparam int MAXM = (GIVE_BRIDGE > TAKE_BRIDGE) ? GIVE_BRIDGE : TAKE_BRIDGE;
  localparam int PW   = $clog2(MAXM + 1);

  timerCtl_t     ctl;
  logic          lpxTick;
  logic          startSeen;
  logic [PW-1:0] periodCnt;

  turn_timer #(.CW(CW), .PW(PW)) u_timer (
    .clk       (clk),
    .rst_n     (rst_n),
    .ctl       (ctl),
    .lpxCycles (lpxCycles),
    .lineIn    (lineIn),
    .lpxTick   (lpxTick),
    .periodCnt (periodCnt),
    .startSeen (startSeen)
  );

  turn_fsm #(
    .PW(PW), .GIVE_BRIDGE(GIVE_BRIDGE), .TAKE_BRIDGE(TAKE_BRIDGE), .SURE_MAX(SURE_MAX)
  ) u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .giveReq   (giveReq),
    .lineIn    (lineIn),
    .startSeen (startSeen),
    .lpxTick   (lpxTick),
    .periodCnt (periodCnt),
    .ctl       (ctl),
    .lineOut   (lineOut),
    .driveEn   (driveEn),
    .isTx      (isTx),
    .turnErr   (turnErr)
  );

endmodule

// File: rtl/lane_turnaround_chk.sv
module lane_turnaround_chk #(
  parameter int CW          = 8,
  parameter int GIVE_BRIDGE = 4,
  parameter int TAKE_BRIDGE = 5
) (
  input logic          clk,
  input logic          rst_n,
  input logic          giveReq,
  input logic [1:0]    lineIn,
  input logic [CW-1:0] lpxCycles,
  input logic [1:0]    lineOut,
  input logic          driveEn,
  input logic          isTx,
  input logic          turnErr
);

  logic        armed;
  logic [1:0]  prevOut;
  logic        prevEn;
  logic [15:0] runLen;
  int          lpxEff;
  logic        segEnd;

  assign lpxEff = (lpxCycles == '0) ? 1 : int'(lpxCycles);
  assign segEnd = armed && ({driveEn, lineOut} != {prevEn, prevOut}) && prevEn
                  && (prevOut != 2'b11);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      armed   <= 1'b0;
      prevOut <= 2'b11;
      prevEn  <= 1'b1;
      runLen  <= '0;
    end else begin
      armed   <= 1'b1;
      prevOut <= lineOut;
      prevEn  <= driveEn;
      if ({driveEn, lineOut} != {prevEn, prevOut}) runLen <= 16'd1;
      else if (runLen != 16'hFFFF)                 runLen <= runLen + 16'd1;
    end
  end

  // R10: driven request and bridge states last at least one LPX
  p_min_len_r10: assert property (@(posedge clk) disable iff (!rst_n)
    segEnd |-> int'(runLen) >= lpxEff);

  // R3: release LP-00 run is (GIVE_BRIDGE+1) LPX long
  p_give_bridge_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (segEnd && prevOut == 2'b00 && !driveEn) |-> int'(runLen) == (GIVE_BRIDGE + 1) * lpxEff);

  // R7: take-over LP-00 run is TAKE_BRIDGE LPX long, ending in stop
  p_take_bridge_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (segEnd && prevOut == 2'b00 && driveEn && lineOut == 2'b11)
      |-> int'(runLen) == TAKE_BRIDGE * lpxEff);

  // R7: ownership is gained only in the stop state
  p_rise_tx_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && $rose(isTx)) |-> (driveEn && lineOut == 2'b11));

  // R3: ownership is given up right after a driven LP-00
  p_fall_tx_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && $fell(isTx)) |-> (!driveEn && $past(driveEn) && $past(lineOut) == 2'b00));

  // R2: a request from stop begins with LP-10
  p_req_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && isTx && driveEn && lineOut == 2'b11 && giveReq) |=> (driveEn && lineOut == 2'b10));

  // R6: driving as the new owner follows a sampled LP-00
  p_take_start_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && $rose(driveEn)) |-> (!isTx && lineOut == 2'b00 && $past(lineIn) == 2'b00));

  // R8: an error always leaves the block listening
  p_err_rx_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && $rose(turnErr)) |-> (!driveEn && !isTx));

  // R4: a request while listening does not grab the lane
  p_rx_ignore_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && !isTx && !driveEn && giveReq) |=> !isTx);

endmodule

bind lane_turnaround lane_turnaround_chk #(
  .CW(CW), .GIVE_BRIDGE(GIVE_BRIDGE), .TAKE_BRIDGE(TAKE_BRIDGE)
) u_chk (
  .clk(clk), .rst_n(rst_n), .giveReq(giveReq), .lineIn(lineIn), .lpxCycles(lpxCycles),
  .lineOut(lineOut), .driveEn(driveEn), .isTx(isTx), .turnErr(turnErr)
);

// File: tb/lane_turnaround_test.sv
module lane_turnaround_test;
  localparam int CW = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          giveReq = 1'b0;
  logic [1:0]    lineIn = 2'b11;
  logic [CW-1:0] lpxCycles = 8'd1;
  logic [1:0]    lineOut;
  logic          driveEn, isTx, turnErr;

  int nChk = 0;
  int nBad = 0;
  bit done = 1'b0;
  bit benchTx = 1'b1;

  always #10 clk = ~clk;

  lane_turnaround #(.CW(CW)) uut (
    .clk(clk), .rst_n(rst_n), .giveReq(giveReq), .lineIn(lineIn), .lpxCycles(lpxCycles),
    .lineOut(lineOut), .driveEn(driveEn), .isTx(isTx), .turnErr(turnErr)
  );

  task automatic chk(string tag, logic [1:0] eo, logic ee, logic et, logic er);
    nChk++;
    if ({lineOut, driveEn, isTx, turnErr} !== {eo, ee, et, er}) begin
      nBad++;
      $display("FAIL %s: got out=%b en=%b tx=%b err=%b, expected out=%b en=%b tx=%b err=%b",
               tag, lineOut, driveEn, isTx, turnErr, eo, ee, et, er);
    end
  endtask

  // Release: start and end at a falling edge; holdReq keeps giveReq high throughout (R4)
  task automatic doRelease(int L, bit holdReq);
    int le = (L == 0) ? 1 : L;
    string t2 = (L == 0) ? "R9" : "R2";
    string t3 = holdReq ? "R4" : "R3";
    giveReq = 1'b1;
    @(negedge clk);
    if (!holdReq) giveReq = 1'b0;
    for (int i = 0; i <= 6 * le + 1; i++) begin
      if (i < le)            chk(t2, 2'b10, 1'b1, 1'b1, 1'b0);
      else if (i < 2 * le)   chk(t2, 2'b00, 1'b1, 1'b1, 1'b0);
      else if (i < 6 * le)   chk(t3, 2'b00, 1'b1, 1'b1, 1'b0);
      else                   chk(t3, 2'b00, 1'b0, 1'b0, 1'b0);
      @(negedge clk);
    end
    giveReq = 1'b0;
    benchTx = 1'b0;
  endtask

  // Take-over: far end shows LP-10, then LP-00 from edge d on (edge 0 samples LP-10)
  task automatic doTake(int L, int d);
    int  le   = (L == 0) ? 1 : L;
    int  g    = (d > le + 1) ? d : le + 1;
    bit  late = (d > 2 * le);
    int  last = late ? 2 * le + 2 : g + 5 * le + 1;
    lineIn = 2'b10;
    @(negedge clk);
    for (int j = 0; j <= last; j++) begin
      if (late) begin
        if (j < 2 * le) chk("R6", 2'b00, 1'b0, 1'b0, 1'b0);
        else            chk("R8", 2'b00, 1'b0, 1'b0, 1'b1);
      end else begin
        if (j < g)               chk("R6", 2'b00, 1'b0, 1'b0, 1'b0);
        else if (j < g + 5 * le) chk("R7", 2'b00, 1'b1, 1'b0, 1'b0);
        else                     chk("R7", 2'b11, 1'b1, 1'b1, 1'b0);
      end
      lineIn = (j + 1 >= d) ? 2'b00 : 2'b10;
      @(negedge clk);
    end
    lineIn = 2'b11;
    benchTx = !late;
  endtask

  // Illegal state one edge into the wait (R8), flag stays set while idle
  task automatic doGlitch(logic [1:0] bad);
    lineIn = 2'b10;
    @(negedge clk);
    chk("R8", 2'b00, 1'b0, 1'b0, 1'b0);
    lineIn = bad;
    @(negedge clk);
    chk("R8", 2'b00, 1'b0, 1'b0, 1'b1);
    lineIn = 2'b11;
    repeat (2) @(negedge clk);
    chk("R8", 2'b00, 1'b0, 1'b0, 1'b1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1", 2'b11, 1'b1, 1'b1, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", 2'b11, 1'b1, 1'b1, 1'b0);

    // R5: owner ignores far-end LP-10
    lineIn = 2'b10;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk("R5", 2'b11, 1'b1, 1'b1, 1'b0);
    end
    lineIn = 2'b11;
    @(negedge clk);

    for (int L = 0; L <= 5; L++) begin
      int le = (L == 0) ? 1 : L;
      int dl[5];
      lpxCycles = CW'(L);
      dl[0] = 1; dl[1] = le; dl[2] = le + 1; dl[3] = 2 * le; dl[4] = 2 * le + 1;
      foreach (dl[n]) begin
        if (benchTx) doRelease(L, (n == 1));
        lineIn = 2'b11;
        repeat (2) @(negedge clk);
        doTake(L, dl[n]);
        repeat (2) @(negedge clk);
      end
      if (benchTx) doRelease(L, 1'b0);
      lineIn = 2'b11;
      @(negedge clk);
      doGlitch(2'b11);
      doGlitch(2'b01);
    end

    // R5: while listening, LP-10 reached from LP-00 does not start a take-over
    lpxCycles = 8'd2;
    lineIn = 2'b00;
    @(negedge clk);
    lineIn = 2'b10;
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      chk("R5", 2'b00, 1'b0, 1'b0, 1'b1);
    end
    lineIn = 2'b11;
    repeat (2) @(negedge clk);
    doTake(2, 3);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    done = 1'b1;
    $finish;
  end

  initial begin
    repeat (150000) @(negedge clk);
    if (!done) begin
      nChk++;
      nBad++;
      $display("FAIL watchdog: got run still active, expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
      $finish;
    end
  end

endmodule